// File: doc/BRIEF.md
# Channel Device Command Decoder

This block is the front end of one peripheral on a shared processor I/O channel. For each command, the processor puts two 16-bit words on the channel output bus and pulses a strobe. The first word holds an address or a data word. The second holds a 5-bit area code, a 3-bit function code and eight modifier bits. Each device on the channel compares the area code with its own fixed code. Only the device that matches acts on the command.

The block keeps one pending interrupt flag for each of its interrupt sources. Each source is tied, by parameter, to one interrupt level from 2 to 5. The pending flags drive the level request lines. Depending on the function code, the block does one of the following:

- returns its interrupt-status bit for the level being serviced;
- returns its device status word and clears selected pending flags;
- latches control modifiers;
- returns a data word;
- captures a data word;
- starts a cycle-steal transfer in a separate memory-transfer engine.

The input bus is registered. It carries data only in the cycle after a selected strobe and is zero at all other times, so several devices can share it through an OR.

Top module: `chan_dev_decoder`

## Requirements
- R1: While reset is high and in the cycle after it, `ibus`, `irq_req`, `ctrl_q`, `wr_stb` and `cs_start` are all zero.
- R2: A command whose area code (`obus_w1[4:0]`) differs from parameter AREA has no effect: the bus stays zero, no strobe fires, `ctrl_q` is unchanged and no pending flag is cleared.
- R3: The function code is `obus_w1[7:5]`, with these encodings: 001 write, 010 read, 011 sense interrupt, 100 control, 101 initiate write, 110 initiate read, 111 sense device. Code 000 produces no bus drive, no strobe and no state change.
- R4: A high `cond_in[i]` sets pending flag i on the next edge. `irq_req[k]` is high while any pending source assigned to level k+2 is set. When a condition and a clear hit the same flag in the same cycle, the flag stays set.
- R5: Sense interrupt returns a word with only bit ILSW_BIT set if some pending source is assigned to level `svc_level`; otherwise it returns zero.
- R6: Sense device returns `dev_stat` with bit 15-i replaced by pending flag i, using the flags as they were before the command. A 1 in `obus_w1[15-i]` clears pending flag i. Source 0 is the device's highest-priority level.
- R7: Control latches `obus_w1[15:8]` into `ctrl_q`, which holds until the next selected control command.
- R8: Read returns `rd_data` on the input bus.
- R9: Write copies `obus_w0` to `wr_data` and raises `wr_stb` for exactly one cycle.
- R10: Initiate read and initiate write pulse `cs_start` for one cycle, put `obus_w0` on `cs_wca`, and set `cs_dir` to 1 for read and 0 for write.
- R11: `ibus` is nonzero only in the cycle right after a selected strobe whose function returns data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_stb | input | 1 | Command strobe, one cycle |
| obus_w0 | input | 16 | Address or data word |
| obus_w1 | input | 16 | Command word: area, function, modifiers |
| svc_level | input | 3 | Interrupt level being serviced |
| cond_in | input | NSRC | Device interrupt conditions |
| dev_stat | input | 16 | Device status bits |
| rd_data | input | 16 | Word returned on read |
| ibus | output | 16 | Channel input bus, zero when idle |
| irq_req | output | 4 | Request lines for levels 2 to 5 |
| wr_data | output | 16 | Captured write word |
| wr_stb | output | 1 | Write word valid |
| ctrl_q | output | 8 | Latched control modifiers |
| cs_start | output | 1 | Cycle-steal start pulse |
| cs_dir | output | 1 | 1 = initiate read, 0 = initiate write |
| cs_wca | output | 16 | Word count address for the transfer |

## Verification
A pending flag that is wrongly held, lost or cleared shows up on the next edge as a wrong `irq_req` line. It is then visible on the input bus one cycle after the next sense command. A wrong area or function decode shows in the cycle after the strobe, as stray bus data, a missing or extra strobe, or a changed `ctrl_q`. The bench clears pending flags one at a time, including a clear that collides with a new condition, and reads the flags back through the request lines and sense commands.

// File: rtl/chan_dev_pkg.sv
package chan_dev_pkg;

    localparam int WORD_W    = 16;
    localparam int AREA_W    = 5;
    localparam int MOD_W     = 8;
    localparam int LVL_MIN   = 2;
    localparam int IRQ_LINES = 4;

    typedef enum logic [2:0] {
        FN_NONE  = 3'b000,
        FN_WRITE = 3'b001,
        FN_READ  = 3'b010,
        FN_SINT  = 3'b011,
        FN_CTRL  = 3'b100,
        FN_IWR   = 3'b101,
        FN_IRD   = 3'b110,
        FN_SDEV  = 3'b111
    } func_e;

    typedef struct packed {
        logic [MOD_W-1:0]  modif;
        func_e             fn;
        logic [AREA_W-1:0] area;
    } cmd_word_t;

    typedef struct packed {
        logic wr;
        logic rd;
        logic sint;
        logic ctrl;
        logic iwr;
        logic ird;
        logic sdev;
    } act_t;

    function automatic act_t decode_fn(input func_e fn);
        act_t a;
        a = '0;
        case (fn)
            FN_WRITE: a.wr   = 1'b1;
            FN_READ:  a.rd   = 1'b1;
            FN_SINT:  a.sint = 1'b1;
            FN_CTRL:  a.ctrl = 1'b1;
            FN_IWR:   a.iwr  = 1'b1;
            FN_IRD:   a.ird  = 1'b1;
            FN_SDEV:  a.sdev = 1'b1;
            default:  a      = '0;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/cdd_match.sv
module cdd_match
    import chan_dev_pkg::*;
#(
    parameter logic [AREA_W-1:0] AREA = 5'd9
) (
    input  logic      stb,
    input  cmd_word_t cmd,
    output act_t      act
);
    logic sel;

    always_comb begin
        sel = stb && (cmd.area == AREA);
        act = sel ? decode_fn(cmd.fn) : '0;
    end
endmodule

// File: rtl/cdd_irq.sv
module cdd_irq
    import chan_dev_pkg::*;
#(
    parameter int               NSRC    = 2,
    parameter logic [NSRC*3-1:0] SRC_LVL = {3'd4, 3'd2}
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NSRC-1:0]      cond_in,
    input  logic                 clr_en,
    input  logic [MOD_W-1:0]     modif,
    input  logic [2:0]           svc_level,
    output logic [NSRC-1:0]      pend,
    output logic [IRQ_LINES-1:0] irq_req,
    output logic                 lvl_hit
);
    for (genvar i = 0; i < NSRC; i++) begin : g_src
        localparam logic [2:0] LVL = SRC_LVL[3*i +: 3];
        logic clr_i;
        // source i is cleared by modifier bit 15-i (modif index 7-i)
        assign clr_i = clr_en && modif[MOD_W-1-i];

        always_ff @(posedge clk) begin
            if (rst)
                pend[i] <= 1'b0;
            else if (cond_in[i])
                pend[i] <= 1'b1;
            else if (clr_i)
                pend[i] <= 1'b0;
        end
    end

    always_comb begin
        irq_req = '0;
        lvl_hit = 1'b0;
        for (int i = 0; i < NSRC; i++) begin
            for (int k = 0; k < IRQ_LINES; k++) begin
                if (pend[i] && (SRC_LVL[3*i +: 3] == 3'(k + LVL_MIN)))
                    irq_req[k] = 1'b1;
            end
            if (pend[i] && (SRC_LVL[3*i +: 3] == svc_level))
                lvl_hit = 1'b1;
        end
    end
endmodule

// File: rtl/cdd_resp.sv
module cdd_resp
    import chan_dev_pkg::*;
#(
    parameter int NSRC     = 2,
    parameter int ILSW_BIT = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  act_t              act,
    input  logic [WORD_W-1:0] word0,
    input  logic [MOD_W-1:0]  modif,
    input  logic              lvl_hit,
    input  logic [NSRC-1:0]   pend,
    input  logic [WORD_W-1:0] dev_stat,
    input  logic [WORD_W-1:0] rd_data,
    output logic [WORD_W-1:0] ibus,
    output logic [WORD_W-1:0] wr_data,
    output logic              wr_stb,
    output logic [MOD_W-1:0]  ctrl_q,
    output logic              cs_start,
    output logic              cs_dir,
    output logic [WORD_W-1:0] cs_wca
);
    logic [WORD_W-1:0] dsw;
    logic [WORD_W-1:0] ilsw;
    logic [WORD_W-1:0] bus_nx;

    always_comb begin
        dsw = dev_stat;
        for (int i = 0; i < NSRC; i++)
            dsw[WORD_W-1-i] = pend[i];
        ilsw = '0;
        ilsw[ILSW_BIT] = lvl_hit;
        bus_nx = '0;
        if (act.rd)   bus_nx = rd_data;
        if (act.sint) bus_nx = ilsw;
        if (act.sdev) bus_nx = dsw;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ibus     <= '0;
            wr_data  <= '0;
            wr_stb   <= 1'b0;
            ctrl_q   <= '0;
            cs_start <= 1'b0;
            cs_dir   <= 1'b0;
            cs_wca   <= '0;
        end else begin
            ibus     <= bus_nx;
            wr_stb   <= act.wr;
            cs_start <= act.iwr || act.ird;
            if (act.wr)   wr_data <= word0;
            if (act.ctrl) ctrl_q  <= modif;
            if (act.iwr || act.ird) begin
                cs_dir <= act.ird;
                cs_wca <= word0;
            end
        end
    end
endmodule

// File: rtl/chan_dev_decoder.sv
module chan_dev_decoder
    import chan_dev_pkg::*;
#(
    parameter logic [4:0]        AREA     = 5'd9,
    parameter int                ILSW_BIT = 4,
    parameter int                NSRC     = 2,
    parameter logic [NSRC*3-1:0] SRC_LVL  = {3'd4, 3'd2}
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cmd_stb,
    input  logic [15:0]     obus_w0,
    input  logic [15:0]     obus_w1,
    input  logic [2:0]      svc_level,
    input  logic [NSRC-1:0] cond_in,
    input  logic [15:0]     dev_stat,
    input  logic [15:0]     rd_data,
    output logic [15:0]     ibus,
    output logic [3:0]      irq_req,
    output logic [15:0]     wr_data,
    output logic            wr_stb,
    output logic [7:0]      ctrl_q,
    output logic            cs_start,
    output logic            cs_dir,
    output logic [15:0]     cs_wca
);
    cmd_word_t       cmd;
    act_t            act;
    logic [NSRC-1:0] pend;
    logic            lvl_hit;

    assign cmd = cmd_word_t'(obus_w1);

    cdd_match #(.AREA(AREA)) u_match (
        .stb (cmd_stb),
        .cmd (cmd),
        .act (act)
    );

    cdd_irq #(.NSRC(NSRC), .SRC_LVL(SRC_LVL)) u_irq (
        .clk       (clk),
        .rst       (rst),
        .cond_in   (cond_in),
        .clr_en    (act.sdev),
        .modif     (cmd.modif),
        .svc_level (svc_level),
        .pend      (pend),
        .irq_req   (irq_req),
        .lvl_hit   (lvl_hit)
    );

    cdd_resp #(.NSRC(NSRC), .ILSW_BIT(ILSW_BIT)) u_resp (
        .clk      (clk),
        .rst      (rst),
        .act      (act),
        .word0    (obus_w0),
        .modif    (cmd.modif),
        .lvl_hit  (lvl_hit),
        .pend     (pend),
        .dev_stat (dev_stat),
        .rd_data  (rd_data),
        .ibus     (ibus),
        .wr_data  (wr_data),
        .wr_stb   (wr_stb),
        .ctrl_q   (ctrl_q),
        .cs_start (cs_start),
        .cs_dir   (cs_dir),
        .cs_wca   (cs_wca)
    );
endmodule

// File: rtl/chan_dev_decoder_chk.sv
module chan_dev_decoder_chk #(
    parameter logic [4:0] AREA = 5'd9,
    parameter int         NSRC = 2
) (
    input logic            clk,
    input logic            rst,
    input logic            cmd_stb,
    input logic [7:0]      cmd_lo,
    input logic [NSRC-1:0] cond_in,
    input logic [15:0]     ibus,
    input logic [3:0]      irq_req,
    input logic            wr_stb,
    input logic [7:0]      ctrl_q,
    input logic            cs_start
);
    // R11
    idle_bus_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(cmd_stb) |-> ibus == 16'h0000);

    // R9
    wr_origin_chk: assert property (@(posedge clk) disable iff (rst)
        wr_stb |-> ($past(cmd_stb) && $past(cmd_lo) == {3'b001, AREA}));

    // R10
    cs_origin_chk: assert property (@(posedge clk) disable iff (rst)
        cs_start |-> $past(cmd_stb) && ($past(cmd_lo[4:0]) == AREA));

    // R7
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(cmd_stb) |-> $stable(ctrl_q));

    // R4
    cond_raise_chk: assert property (@(posedge clk) disable iff (rst)
        (|cond_in) |=> (irq_req != 4'b0000));
endmodule

bind chan_dev_decoder chan_dev_decoder_chk #(.AREA(AREA), .NSRC(NSRC)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cmd_stb  (cmd_stb),
    .cmd_lo   (obus_w1[7:0]),
    .cond_in  (cond_in),
    .ibus     (ibus),
    .irq_req  (irq_req),
    .wr_stb   (wr_stb),
    .ctrl_q   (ctrl_q),
    .cs_start (cs_start)
);

// File: tb/chan_dev_decoder_tb.sv
module chan_dev_decoder_tb;
    localparam logic [4:0] AREA = 5'd9;
    localparam int ILSW_BIT = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_stb = 1'b0;
    logic [15:0] obus_w0 = '0;
    logic [15:0] obus_w1 = '0;
    logic [2:0]  svc_level = '0;
    logic [1:0]  cond_in = '0;
    logic [15:0] dev_stat = '0;
    logic [15:0] rd_data = '0;
    logic [15:0] ibus, wr_data, cs_wca;
    logic [3:0]  irq_req;
    logic        wr_stb, cs_start, cs_dir;
    logic [7:0]  ctrl_q;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    chan_dev_decoder #(.AREA(AREA), .ILSW_BIT(ILSW_BIT), .NSRC(2),
                       .SRC_LVL({3'd4, 3'd2})) u_dut (
        .clk(clk), .rst(rst), .cmd_stb(cmd_stb), .obus_w0(obus_w0),
        .obus_w1(obus_w1), .svc_level(svc_level), .cond_in(cond_in),
        .dev_stat(dev_stat), .rd_data(rd_data), .ibus(ibus),
        .irq_req(irq_req), .wr_data(wr_data), .wr_stb(wr_stb),
        .ctrl_q(ctrl_q), .cs_start(cs_start), .cs_dir(cs_dir),
        .cs_wca(cs_wca)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one strobe; returns at the negedge after the capturing edge
    task automatic issue(input logic [4:0] area, input logic [2:0] fn,
                         input logic [7:0] md, input logic [15:0] w0);
        @(negedge clk);
        obus_w0 = w0;
        obus_w1 = {md, fn, area};
        cmd_stb = 1'b1;
        @(negedge clk);
        cmd_stb = 1'b0;
        obus_w1 = '0;
    endtask

    task automatic pulse_cond(input logic [1:0] c);
        @(negedge clk);
        cond_in = c;
        @(negedge clk);
        cond_in = '0;
    endtask

    task automatic t_reset;
        chk("R1 ibus", ibus, 16'h0);
        chk("R1 irq_req", {12'h0, irq_req}, 16'h0);
        chk("R1 ctrl_q", {8'h0, ctrl_q}, 16'h0);
        chk("R1 strobes", {14'h0, wr_stb, cs_start}, 16'h0);
    endtask

    task automatic t_conditions;
        pulse_cond(2'b01);
        chk("R4 level2 line", {12'h0, irq_req}, 16'h0001);
        pulse_cond(2'b10);
        chk("R4 level4 line", {12'h0, irq_req}, 16'h0005);
    endtask

    task automatic t_sense_int;
        svc_level = 3'd2;
        issue(AREA, 3'b011, 8'h00, 16'h0);
        chk("R5 level2 hit", ibus, 16'h0010);
        @(negedge clk);
        chk("R11 bus idle after", ibus, 16'h0);
        svc_level = 3'd3;
        issue(AREA, 3'b011, 8'h00, 16'h0);
        chk("R5 level3 miss", ibus, 16'h0);
        svc_level = 3'd4;
        issue(AREA, 3'b011, 8'h00, 16'h0);
        chk("R5 level4 hit", ibus, 16'h0010);
    endtask

    task automatic t_sense_dev;
        dev_stat = 16'h00A5;
        issue(AREA, 3'b111, 8'h80, 16'h0);
        chk("R6 dsw", ibus, 16'hC0A5);
        chk("R6 clear src0", {12'h0, irq_req}, 16'h0004);
        issue(5'd3, 3'b111, 8'h40, 16'h0);
        chk("R2 foreign area no clear", {12'h0, irq_req}, 16'h0004);
        chk("R2 foreign area bus", ibus, 16'h0);
        issue(AREA, 3'b111, 8'h40, 16'h0);
        chk("R6 dsw after first clear", ibus, 16'h40A5);
        chk("R6 clear src1", {12'h0, irq_req}, 16'h0);
        // collision: condition and clear of source 0 together
        @(negedge clk);
        cond_in = 2'b01;
        obus_w1 = {8'h80, 3'b111, AREA};
        cmd_stb = 1'b1;
        @(negedge clk);
        cond_in = '0;
        cmd_stb = 1'b0;
        chk("R4 set wins", {12'h0, irq_req}, 16'h0001);
        issue(AREA, 3'b111, 8'h80, 16'h0);
        chk("R6 final clear", {12'h0, irq_req}, 16'h0);
    endtask

    task automatic t_ctrl;
        issue(AREA, 3'b100, 8'h3C, 16'hFFFF);
        chk("R7 latch", {8'h0, ctrl_q}, 16'h003C);
        chk("R7 no bus", ibus, 16'h0);
        rd_data = 16'hBEEF;
        issue(AREA, 3'b010, 8'h55, 16'h0);
        chk("R7 hold across read", {8'h0, ctrl_q}, 16'h003C);
        chk("R8 read word", ibus, 16'hBEEF);
        @(negedge clk);
        chk("R11 read released", ibus, 16'h0);
        issue(5'd8, 3'b100, 8'hAA, 16'h0);
        chk("R2 foreign control", {8'h0, ctrl_q}, 16'h003C);
    endtask

    task automatic t_write;
        issue(AREA, 3'b001, 8'h00, 16'h1234);
        chk("R9 data", wr_data, 16'h1234);
        chk("R9 strobe", {15'h0, wr_stb}, 16'h1);
        chk("R11 write no bus", ibus, 16'h0);
        @(negedge clk);
        chk("R9 strobe single", {15'h0, wr_stb}, 16'h0);
        issue(5'd10, 3'b001, 8'h00, 16'h5678);
        chk("R2 foreign write", {15'h0, wr_stb}, 16'h0);
    endtask

    task automatic t_init;
        issue(AREA, 3'b110, 8'h00, 16'h0400);
        chk("R10 read start", {14'h0, cs_start, cs_dir}, 16'h3);
        chk("R10 wca", cs_wca, 16'h0400);
        @(negedge clk);
        chk("R10 pulse single", {15'h0, cs_start}, 16'h0);
        issue(AREA, 3'b101, 8'h00, 16'h0800);
        chk("R10 write start", {14'h0, cs_start, cs_dir}, 16'h2);
        chk("R10 wca write", cs_wca, 16'h0800);
    endtask

    task automatic t_unknown;
        rd_data = 16'hFFFF;
        issue(AREA, 3'b000, 8'hFF, 16'h9999);
        chk("R3 code000 bus", ibus, 16'h0);
        chk("R3 code000 strobes", {14'h0, wr_stb, cs_start}, 16'h0);
        chk("R3 code000 ctrl", {8'h0, ctrl_q}, 16'h003C);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_conditions();
        t_sense_int();
        t_sense_dev();
        t_ctrl();
        t_write();
        t_init();
        t_unknown();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule